// File: doc/BRIEF.md
# Return-Address Stack and Branch Unit

This block decides where a small 8-bit processor core goes next after a control-flow instruction. The decoder hands it one request per cycle. A request is one of four kinds: jump, call, return or restart, which is a short vectored call. Any request except a restart may be made conditional on one of four condition flags, with a polarity bit that says whether the instruction acts when that flag is set or when it is clear. The unit also receives the two immediate address bytes and the fall-through address, which is the address of the next instruction in sequence.

Return addresses live in a private circular stack of eight 14-bit entries. A hidden 3-bit pointer indexes the stack, and software cannot read it. The pointer wraps in both directions. Nothing guards against overflow: a ninth nested call quietly replaces the oldest saved address.

The cycle after each request, the unit presents four things: the new program counter, whether the transfer was taken, how many machine states the instruction costs, and a one-cycle done strobe. The program counter register keeps its value while no request arrives.

Top module: `retstack_branch_unit`

## Requirements
- R1: While reset is asserted and after it releases, `pc_o` is 0, `taken_o` is 0, `states_o` is 0 and `done_o` is 0. The stack pointer is 0 and every stack entry is 0, so a return issued first after reset loads 0.
- R2: The jump or call target is `{tgt_hi_i, tgt_lo_i}` (high byte times 256 plus low byte) masked to its low 14 bits. A taken jump or call loads this target into `pc_o`, sets `taken_o` to 1 and reports 11 states.
- R3: `req_cond_i`=1 makes a jump, call or return conditional. `req_csel_i` picks the flag `flags_i[req_csel_i]`, where bit 0 is carry, bit 1 zero, bit 2 sign and bit 3 parity. The instruction acts only when that flag equals `req_polarity_i`. With `req_cond_i`=0 it always acts.
- R4: A jump or call that does not act loads `fallthru_i` into `pc_o`, sets `taken_o` to 0, reports 9 states and leaves the stack untouched.
- R5: A call that acts writes `fallthru_i` into the entry at the pointer and then advances the pointer by one. A return that acts first steps the pointer back by one and then loads `pc_o` from that entry. Return addresses therefore come back in last-in, first-out order.
- R6: A return that acts reports 5 states with `taken_o`=1. A return that does not act loads `fallthru_i`, reports 3 states with `taken_o`=0 and does not pop.
- R7: A restart (`req_kind_i`=3) always acts, whatever the condition inputs say. It pushes `fallthru_i` and loads `req_vec_i`×8 into `pc_o`, so targets 0, 8, …, 56. It reports 5 states with `taken_o`=1.
- R8: The pointer wraps modulo 8 on both push and pop. After nine calls in a row, the ninth address has overwritten the oldest one. Nine returns then give back the ninth, eighth, …, second addresses, and after those the ninth address again.
- R9: A cycle with `req_valid_i`=0 leaves `pc_o` and the stack unchanged and drives `done_o` to 0 in the following cycle. `req_kind_i` encoding: 0 jump, 1 call, 2 return, 3 restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A control-flow request is present this cycle |
| req_kind_i | input | 2 | 0 jump, 1 call, 2 return, 3 restart |
| req_cond_i | input | 1 | Request is conditional |
| req_polarity_i | input | 1 | Flag value on which a conditional request acts |
| req_csel_i | input | 2 | Flag select: 0 carry, 1 zero, 2 sign, 3 parity |
| flags_i | input | 4 | Condition flags {parity, sign, zero, carry} |
| tgt_lo_i | input | 8 | Low immediate address byte |
| tgt_hi_i | input | 8 | High immediate address byte |
| req_vec_i | input | 3 | Restart vector number |
| fallthru_i | input | 14 | Address of the next sequential instruction |
| pc_o | output | 14 | Program counter after the last request |
| taken_o | output | 1 | Last request transferred control |
| states_o | output | 4 | Machine-state cost of the last request |
| done_o | output | 1 | Outputs were updated by a request last cycle |

## Verification
On the ninth nested call, two functions happen in the same clock edge. The write of the return address lands on the oldest entry, and the pointer wraps from 7 back to 0. The bench triggers this with nine calls in a row followed by nine returns. The scoreboard's own stack model expects the ninth address at the top and again after the pointer has wrapped around. A return issued in the cycle right after a call or restart checks a second case: a read of an entry that the previous edge wrote.

// File: rtl/rbu_pkg.sv
package rbu_pkg;

   typedef enum logic [1:0] {
      K_JUMP    = 2'd0,
      K_CALL    = 2'd1,
      K_RET     = 2'd2,
      K_RESTART = 2'd3
   } req_kind_e;

endpackage

// File: rtl/rbu_cond_sel.sv
module rbu_cond_sel #(
   parameter int N_FLAGS = 4,
   parameter int SEL_W   = $clog2(N_FLAGS)
) (
   input  logic [N_FLAGS-1:0] flags_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic               polarity_i,
   input  logic               conditional_i,
   output logic               pass_o
);

   logic picked;

   assign picked = flags_i[sel_i];
   assign pass_o = !conditional_i || (picked == polarity_i);

endmodule

// File: rtl/rbu_target.sv
module rbu_target #(
   parameter int BYTE_W    = 8,
   parameter int PC_W      = 14,
   parameter int VEC_W     = 3,
   parameter int VEC_SHIFT = 3
) (
   input  logic [BYTE_W-1:0] hi_i,
   input  logic [BYTE_W-1:0] lo_i,
   input  logic [VEC_W-1:0]  vec_i,
   output logic [PC_W-1:0]   jump_tgt_o,
   output logic [PC_W-1:0]   vec_tgt_o
);

   localparam int RAW_W = 2 * BYTE_W;

   logic [RAW_W-1:0] raw;
   assign raw = {hi_i, lo_i};

   generate
      if (PC_W <= RAW_W) begin : g_trunc
         assign jump_tgt_o = raw[PC_W-1:0];
      end else begin : g_zext
         assign jump_tgt_o = {{(PC_W-RAW_W){1'b0}}, raw};
      end
   endgenerate

   assign vec_tgt_o = PC_W'(vec_i) << VEC_SHIFT;

endmodule

// File: rtl/rbu_stack.sv
module rbu_stack #(
   parameter int PC_W  = 14,
   parameter int DEPTH = 8,
   parameter int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [PC_W-1:0]  wdata_i,
   output logic [PC_W-1:0]  rdata_o,
   output logic [PTR_W-1:0] sp_o
);

   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("rbu_stack: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [PC_W-1:0]  ent_q [DEPTH];
   logic [PTR_W-1:0] sp_q;
   logic [PTR_W-1:0] sp_dec;

   assign sp_dec  = sp_q - PTR_W'(1);
   assign rdata_o = ent_q[sp_dec];
   assign sp_o    = sp_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sp_q <= '0;
         for (int e = 0; e < DEPTH; e++) ent_q[e] <= '0;
      end else if (push_i) begin
         ent_q[sp_q] <= wdata_i;
         sp_q        <= sp_q + PTR_W'(1);
      end else if (pop_i) begin
         sp_q <= sp_dec;
      end
   end

endmodule

// File: rtl/retstack_branch_unit.sv
module retstack_branch_unit
   import rbu_pkg::*;
#(
   parameter int PC_W         = 14,
   parameter int BYTE_W       = 8,
   parameter int DEPTH        = 8,
   parameter int N_FLAGS      = 4,
   parameter int VEC_W        = 3,
   parameter int VEC_SHIFT    = 3,
   parameter int ST_W         = 4,
   parameter int ST_JMP_TAKEN = 11,
   parameter int ST_JMP_SKIP  = 9,
   parameter int ST_RET_TAKEN = 5,
   parameter int ST_RET_SKIP  = 3,
   parameter int ST_RESTART   = 5,
   localparam int CSEL_W      = $clog2(N_FLAGS),
   localparam int PTR_W       = $clog2(DEPTH)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               req_valid_i,
   input  logic [1:0]         req_kind_i,
   input  logic               req_cond_i,
   input  logic               req_polarity_i,
   input  logic [CSEL_W-1:0]  req_csel_i,
   input  logic [N_FLAGS-1:0] flags_i,
   input  logic [BYTE_W-1:0]  tgt_lo_i,
   input  logic [BYTE_W-1:0]  tgt_hi_i,
   input  logic [VEC_W-1:0]   req_vec_i,
   input  logic [PC_W-1:0]    fallthru_i,
   output logic [PC_W-1:0]    pc_o,
   output logic               taken_o,
   output logic [ST_W-1:0]    states_o,
   output logic               done_o
);

   generate
      if (PC_W > 2 * BYTE_W) begin : g_bad_pc
         $error("retstack_branch_unit: PC_W exceeds two address bytes");
      end
      if (VEC_W + VEC_SHIFT > PC_W) begin : g_bad_vec
         $error("retstack_branch_unit: restart vectors do not fit the PC");
      end
      if (N_FLAGS != (1 << CSEL_W)) begin : g_bad_flags
         $error("retstack_branch_unit: N_FLAGS must be a power of two");
      end
      if (ST_JMP_TAKEN >= (1 << ST_W)) begin : g_bad_st
         $error("retstack_branch_unit: ST_W too narrow for state counts");
      end
   endgenerate

   req_kind_e         kind;
   logic              pass_w;
   logic              push_w;
   logic              pop_w;
   logic [PC_W-1:0]   jump_tgt_w;
   logic [PC_W-1:0]   vec_tgt_w;
   logic [PC_W-1:0]   ret_addr_w;
   logic [PTR_W-1:0]  sp_w;

   logic [PC_W-1:0]   nxt_pc;
   logic              nxt_taken;
   logic [ST_W-1:0]   nxt_st;

   logic [PC_W-1:0]   pc_q;
   logic              taken_q;
   logic [ST_W-1:0]   states_q;
   logic              done_q;

   assign kind = req_kind_e'(req_kind_i);

   rbu_cond_sel #(
      .N_FLAGS (N_FLAGS)
   ) u_cond (
      .flags_i       (flags_i),
      .sel_i         (req_csel_i),
      .polarity_i    (req_polarity_i),
      .conditional_i (req_cond_i),
      .pass_o        (pass_w)
   );

   rbu_target #(
      .BYTE_W    (BYTE_W),
      .PC_W      (PC_W),
      .VEC_W     (VEC_W),
      .VEC_SHIFT (VEC_SHIFT)
   ) u_tgt (
      .hi_i       (tgt_hi_i),
      .lo_i       (tgt_lo_i),
      .vec_i      (req_vec_i),
      .jump_tgt_o (jump_tgt_w),
      .vec_tgt_o  (vec_tgt_w)
   );

   // A restart ignores the condition; calls and restarts push when acting.
   assign push_w = req_valid_i &&
                   ((kind == K_RESTART) || ((kind == K_CALL) && pass_w));
   assign pop_w  = req_valid_i && (kind == K_RET) && pass_w;

   rbu_stack #(
      .PC_W  (PC_W),
      .DEPTH (DEPTH)
   ) u_stack (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push_w),
      .pop_i   (pop_w),
      .wdata_i (fallthru_i),
      .rdata_o (ret_addr_w),
      .sp_o    (sp_w)
   );

   always_comb begin
      nxt_pc    = fallthru_i;
      nxt_taken = 1'b0;
      nxt_st    = ST_W'(ST_JMP_SKIP);
      unique case (kind)
         K_JUMP, K_CALL: begin
            nxt_taken = pass_w;
            if (pass_w) begin
               nxt_pc = jump_tgt_w;
               nxt_st = ST_W'(ST_JMP_TAKEN);
            end
         end
         K_RET: begin
            nxt_taken = pass_w;
            nxt_st    = pass_w ? ST_W'(ST_RET_TAKEN) : ST_W'(ST_RET_SKIP);
            if (pass_w) nxt_pc = ret_addr_w;
         end
         K_RESTART: begin
            nxt_taken = 1'b1;
            nxt_pc    = vec_tgt_w;
            nxt_st    = ST_W'(ST_RESTART);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pc_q     <= '0;
         taken_q  <= 1'b0;
         states_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= req_valid_i;
         if (req_valid_i) begin
            pc_q     <= nxt_pc;
            taken_q  <= nxt_taken;
            states_q <= nxt_st;
         end
      end
   end

   assign pc_o     = pc_q;
   assign taken_o  = taken_q;
   assign states_o = states_q;
   assign done_o   = done_q;

endmodule

// File: rtl/retstack_branch_chk.sv
module retstack_branch_chk #(
   parameter int PC_W      = 14,
   parameter int PTR_W     = 3,
   parameter int VEC_W     = 3,
   parameter int VEC_SHIFT = 3,
   parameter int ST_W      = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             req_valid_i,
   input logic [1:0]       req_kind_i,
   input logic [VEC_W-1:0] req_vec_i,
   input logic [PC_W-1:0]  fallthru_i,
   input logic [PC_W-1:0]  pc_o,
   input logic             taken_o,
   input logic [ST_W-1:0]  states_o,
   input logic             done_o,
   input logic             push,
   input logic             pop,
   input logic [PTR_W-1:0] sp
);

   // R4 / R2: jump and call cost 11 states when taken, 9 otherwise
   p_jmp_states_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && (req_kind_i == 2'd0 || req_kind_i == 2'd1)) |=>
      (done_o && (taken_o ? (states_o == ST_W'(11)) : (states_o == ST_W'(9)))));

   // R6: return costs 5 states when taken, 3 otherwise
   p_ret_states_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_kind_i == 2'd2) |=>
      (taken_o ? (states_o == ST_W'(5)) : (states_o == ST_W'(3))));

   // R7: restart always taken, lands on vector times 8
   p_restart_vec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_kind_i == 2'd3) |=>
      (taken_o && states_o == ST_W'(5) &&
       pc_o == (PC_W'($past(req_vec_i)) << VEC_SHIFT)));

   // R4: a request that does not act falls through
   p_skip_fallthru_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_kind_i != 2'd3) |=>
      (taken_o || pc_o == $past(fallthru_i)));

   // R5: never a push and a pop together
   p_push_pop_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(push && pop));

   // R8: pointer advances modulo 8 on a push
   p_ptr_push_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push |=> (sp == $past(sp) + PTR_W'(1)));

   // R8: pointer steps back modulo 8 on a pop
   p_ptr_pop_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop |=> (sp == $past(sp) - PTR_W'(1)));

   // R9: idle cycle keeps the PC and the pointer
   p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |=> (!done_o && $stable(pc_o) && $stable(sp)));

endmodule

bind retstack_branch_unit retstack_branch_chk #(
   .PC_W      (PC_W),
   .PTR_W     (PTR_W),
   .VEC_W     (VEC_W),
   .VEC_SHIFT (VEC_SHIFT),
   .ST_W      (ST_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .req_valid_i (req_valid_i),
   .req_kind_i  (req_kind_i),
   .req_vec_i   (req_vec_i),
   .fallthru_i  (fallthru_i),
   .pc_o        (pc_o),
   .taken_o     (taken_o),
   .states_o    (states_o),
   .done_o      (done_o),
   .push        (push_w),
   .pop         (pop_w),
   .sp          (sp_w)
);

// File: tb/retstack_branch_unit_test.sv
`timescale 1ns/1ps
module retstack_branch_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic        req_cond = 1'b0;
   logic        req_pol = 1'b0;
   logic [1:0]  req_csel = 2'd0;
   logic [3:0]  flags = 4'd0;
   logic [7:0]  tgt_lo = 8'd0;
   logic [7:0]  tgt_hi = 8'd0;
   logic [2:0]  req_vec = 3'd0;
   logic [13:0] fallthru = 14'd0;
   logic [13:0] pc;
   logic        taken;
   logic [3:0]  states;
   logic        done;

   always #5 clk = ~clk;

   retstack_branch_unit uut (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .req_valid_i    (req_valid),
      .req_kind_i     (req_kind),
      .req_cond_i     (req_cond),
      .req_polarity_i (req_pol),
      .req_csel_i     (req_csel),
      .flags_i        (flags),
      .tgt_lo_i       (tgt_lo),
      .tgt_hi_i       (tgt_hi),
      .req_vec_i      (req_vec),
      .fallthru_i     (fallthru),
      .pc_o           (pc),
      .taken_o        (taken),
      .states_o       (states),
      .done_o         (done)
   );

   typedef struct {
      logic [13:0] pc;
      logic        taken;
      logic [3:0]  st;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          total = 0;
   int          bad = 0;
   logic [13:0] m_pc = 14'd0;
   logic [13:0] m_stk [8];
   logic [2:0]  m_sp = 3'd0;

   task automatic issue(input logic [1:0] k, input logic c, input logic pol,
                        input logic [1:0] cs, input logic [3:0] fl,
                        input logic [7:0] hi, input logic [7:0] lo,
                        input logic [2:0] vec, input logic [13:0] ft,
                        input string tag);
      exp_t        e;
      logic        ok;
      logic [13:0] tgt;
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_cond = c; req_pol = pol;
      req_csel = cs; flags = fl; tgt_hi = hi; tgt_lo = lo;
      req_vec = vec; fallthru = ft;
      tgt = 14'({hi, lo} & 16'h3FFF);
      ok  = (k == 2'd3) || !c || (fl[cs] == pol);
      case (k)
         2'd0: begin m_pc = ok ? tgt : ft; e.st = ok ? 4'd11 : 4'd9; end
         2'd1: begin
            if (ok) begin m_stk[m_sp] = ft; m_sp = m_sp + 3'd1; m_pc = tgt; end
            else m_pc = ft;
            e.st = ok ? 4'd11 : 4'd9;
         end
         2'd2: begin
            if (ok) begin m_sp = m_sp - 3'd1; m_pc = m_stk[m_sp]; end
            else m_pc = ft;
            e.st = ok ? 4'd5 : 4'd3;
         end
         default: begin
            m_stk[m_sp] = ft; m_sp = m_sp + 3'd1;
            m_pc = {8'd0, vec, 3'd0}; e.st = 4'd5;
         end
      endcase
      e.pc = m_pc; e.taken = ok; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Monitor: pop one expected item per done strobe
   always @(negedge clk) begin
      if (rst_n && done) begin
         exp_t e;
         total++;
         if (sb.size() == 0) begin
            bad++;
            $display("FAIL unexpected done: pc=%h expected no result", pc);
         end else begin
            e = sb.pop_front();
            if (pc !== e.pc || taken !== e.taken || states !== e.st) begin
               bad++;
               $display("FAIL %s: pc=%h/%h taken=%b/%b states=%0d/%0d",
                        e.tag, pc, e.pc, taken, e.taken, states, e.st);
            end
         end
      end
   end

   task automatic check_idle(input string tag);
      total++;
      if (pc !== m_pc || done !== 1'b0) begin
         bad++;
         $display("FAIL %s: pc=%h/%h done=%b/0", tag, pc, m_pc, done);
      end
   endtask

   initial begin
      #1ms;
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) m_stk[i] = 14'd0;
      repeat (3) @(negedge clk);
      // R1: reset values
      total++;
      if (pc !== 14'd0 || taken !== 1'b0 || states !== 4'd0 || done !== 1'b0) begin
         bad++;
         $display("FAIL R1: pc=%h/0 taken=%b/0 states=%0d/0 done=%b/0",
                  pc, taken, states, done);
      end
      rst_n = 1'b1;
      // R1: first return after reset reads a zeroed entry
      issue(2'd2, 1'b0, 1'b0, 2'd0, 4'd0, 8'd0, 8'd0, 3'd0, 14'h0123, "R1");
      issue(2'd1, 1'b0, 1'b0, 2'd0, 4'd0, 8'd0, 8'd0, 3'd0, 14'h0005, "R5");
      // R2: unconditional jump with masking of the high byte
      issue(2'd0, 1'b0, 1'b0, 2'd0, 4'd0, 8'hFF, 8'h34, 3'd0, 14'h0010, "R2");
      issue(2'd0, 1'b0, 1'b0, 2'd0, 4'd0, 8'h12, 8'hAB, 3'd0, 14'h0020, "R2");
      // R3 / R4: every flag select, both polarities, flag set and clear
      for (int cs = 0; cs < 4; cs++)
         for (int pl = 0; pl < 2; pl++)
            for (int fv = 0; fv < 2; fv++) begin
               logic [3:0] fl;
               fl = fv[0] ? (4'd1 << cs) : (~(4'd1 << cs));
               issue(2'd0, 1'b1, pl[0], 2'(cs), fl, 8'(cs + 1), 8'(pl * 16 + fv),
                     3'd0, 14'(14'h0100 + cs * 4 + pl * 2 + fv), "R3");
            end
      idle();
      // R5: nested calls then returns
      issue(2'd1, 1'b0, 1'b0, 2'd0, 4'd0, 8'h01, 8'h00, 3'd0, 14'h0203, "R5");
      issue(2'd1, 1'b0, 1'b0, 2'd0, 4'd0, 8'h02, 8'h00, 3'd0, 14'h0103, "R5");
      // R4: conditional call not acting pushes nothing (zero flag clear, wants set)
      issue(2'd1, 1'b1, 1'b1, 2'd1, 4'b1101, 8'h03, 8'h00, 3'd0, 14'h0206, "R4");
      issue(2'd2, 1'b0, 1'b0, 2'd0, 4'd0, 8'd0, 8'd0, 3'd0, 14'h0207, "R5");
      // R6: conditional return not acting (carry set, wants clear)
      issue(2'd2, 1'b1, 1'b0, 2'd0, 4'b0001, 8'd0, 8'd0, 3'd0, 14'h0104, "R6");
      issue(2'd2, 1'b1, 1'b1, 2'd3, 4'b1000, 8'd0, 8'd0, 3'd0, 14'h0105, "R6");
      // R7: restart ignores a failing condition
      issue(2'd3, 1'b1, 1'b1, 2'd2, 4'b0000, 8'd0, 8'd0, 3'd5, 14'h0301, "R7");
      issue(2'd3, 1'b0, 1'b0, 2'd0, 4'd0, 8'd0, 8'd0, 3'd7, 14'h002A, "R7");
      issue(2'd2, 1'b0, 1'b0, 2'd0, 4'd0, 8'd0, 8'd0, 3'd0, 14'h0039, "R7");
      issue(2'd2, 1'b0, 1'b0, 2'd0, 4'd0, 8'd0, 8'd0, 3'd0, 14'h002B, "R7");
      // R9: idle keeps the PC
      idle();
      idle();
      check_idle("R9");
      // R8: nine calls wrap the pointer, then nine returns
      for (int i = 0; i < 9; i++)
         issue(2'd1, 1'b0, 1'b0, 2'd0, 4'd0, 8'h00, 8'(8'h40 + i), 3'd0,
               14'(14'h0200 + i * 3), "R8");
      for (int i = 0; i < 9; i++)
         issue(2'd2, 1'b0, 1'b0, 2'd0, 4'd0, 8'd0, 8'd0, 3'd0, 14'h3000, "R8");
      idle();
      repeat (3) @(negedge clk);
      check_idle("R9");
      wait (sb.size() == 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule